// File: doc/BRIEF.md
# Wait-State Memory Slave

This block sits on the memory side of a synchronous, single-master bus. It holds a small word array and answers the master's requests. A request is marked by a memory-select strobe, and a read/write line tells loads from stores. While the select strobe is low, the bus is carrying an I/O transfer or nothing at all, and the slave stays quiet. The slave has an access latency, set in clock cycles by a parameter. When a word cannot be delivered in the cycle after the request, the slave raises a wait line. This stretches the transfer one cycle at a time. The slave drops the wait line at the start of the cycle in which it will surely deliver. That cycle is the data cycle.

In the data cycle of a read, the slave enables its read-data output and presents the stored word. The word is valid from the start of that cycle, so a master that samples mid-cycle sees settled data. In the data cycle of a write, the slave stores the master's write data on the rising edge that closes the cycle. The address is captured once, on the first rising edge that sees the select strobe. The kind of access is captured on that same edge. If the master drops the select strobe early, the transfer is abandoned.

Top module: `wait_mem_slave`

## Requirements
- R1: After reset, waitOut and rdDataEn are 0, and every array word reads back as 0.
- R2: While memSel is 0 (an I/O transfer or an idle bus), the slave raises neither waitOut nor rdDataEn, and it stores nothing, whatever readNotWrite, addrIn and wrData carry.
- R3: An access starts on the first rising edge at which memSel is 1 while the slave is idle. addrIn is captured on that edge. Later changes of addrIn within the access have no effect.
- R4: With LATENCY greater than 1, waitOut is 1 for exactly LATENCY-1 cycles, starting in the cycle after the start edge. With LATENCY equal to 1, waitOut is never 1.
- R5: The data cycle is the LATENCY-th cycle after the start edge. waitOut is 0 in that cycle.
- R6: rdDataEn is 1 only during the data cycle of a read, and only while memSel and readNotWrite are both still 1. In that case rdData equals the word at the captured address. Whenever rdDataEn is 0, rdData is 0.
- R7: An access is a write when readNotWrite is 0 on the start edge. wrData is stored at the captured address on the rising edge that ends the data cycle, provided memSel and readNotWrite=0 hold on that edge.
- R8: If memSel is 0 on any rising edge after the start edge, the access is abandoned. The slave returns to idle on that edge, waitOut is 0 in the next cycle, and nothing is stored.
- R9: The slave is idle in the cycle after the data cycle, even if memSel stays 1. If memSel is still 1 at the end of that cycle, a new access starts on that edge.
- R10: The kind of access is fixed on the start edge. If readNotWrite is dropped during the data cycle of a read, rdDataEn falls at once and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all activity on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| memSel | input | 1 | Memory-select strobe from the master, active high |
| readNotWrite | input | 1 | 1 for a read, 0 for a write |
| addrIn | input | ADDR_W | Word address from the master |
| wrData | input | DATA_W | Write data from the master |
| rdData | output | DATA_W | Read data; 0 whenever rdDataEn is 0 |
| rdDataEn | output | 1 | Read-data output enable |
| waitOut | output | 1 | Wait request; stretches the current transfer |

## Verification
The data cycle of an access can coincide with the master withdrawing it. Its closing edge can carry both a write commit and a select strobe that is already low. A read's enable can also be live while readNotWrite is pulled away within the same cycle.

The bench provokes both cases on a three-cycle and a one-cycle instance:
- It drops memSel before the closing edge of a write.
- It drops readNotWrite in the middle of a read's data cycle.

These coincidences are judged at the ports. The bench checks that rdDataEn falls within the cycle. It also reads the affected addresses back afterwards and checks that they still hold their old values. Full sweeps of back-to-back writes and reads over every address confirm that the wait length and the data cycle are correct for each latency.

// File: rtl/wms_pkg.sv
package wms_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STRETCH = 2'd1,
    PH_DELIVER = 2'd2
  } phase_t;

  // Strobes sent from control to the datapath
  typedef struct packed {
    logic latchAddr;  // capture the address this edge
    logic storeWord;  // commit write data this edge
    logic driveRead;  // present the stored word on the read port
  } strobe_t;

endpackage

// File: rtl/wms_ctrl.sv
module wms_ctrl
  import wms_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    memSel,
  input  logic    readNotWrite,
  output strobe_t strobes,
  output logic    waitOut
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) + 1 : 1;
  localparam int RUN_W = $clog2(LATENCY + 1) + 1;

  phase_t           phase;
  logic [CNT_W-1:0] waitLeft;
  logic             isReadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      waitLeft <= '0;
      isReadQ  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (memSel) begin
            isReadQ <= readNotWrite;
            if (LATENCY <= 1) begin
              phase <= PH_DELIVER;
            end else begin
              phase    <= PH_STRETCH;
              waitLeft <= CNT_W'(LATENCY - 1);
            end
          end
        end
        PH_STRETCH: begin
          if (!memSel) begin
            phase <= PH_IDLE;
          end else if (waitLeft == CNT_W'(1)) begin
            phase <= PH_DELIVER;
          end else begin
            waitLeft <= waitLeft - CNT_W'(1);
          end
        end
        PH_DELIVER: begin
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.latchAddr = (phase == PH_IDLE) && memSel;
    strobes.storeWord = (phase == PH_DELIVER) && !isReadQ && memSel && !readNotWrite;
    strobes.driveRead = (phase == PH_DELIVER) && isReadQ && memSel && readNotWrite;
    waitOut           = (phase == PH_STRETCH);
  end

  // Length of the current wait run, used by the checks below
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else       runLen <= waitOut ? runLen + RUN_W'(1) : '0;
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !memSel) |=> !waitOut);

  assert_wait_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= RUN_W'(LATENCY - 1));

  assert_no_drive_in_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |-> !strobes.driveRead);

  assert_abandon_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STRETCH && !memSel) |=> (phase == PH_IDLE));

  assert_single_data_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DELIVER) |=> (phase == PH_IDLE));

endmodule

// File: rtl/wms_datapath.sv
module wms_datapath
  import wms_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] rows [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  addrQ <= '0;
    else if (strobes.latchAddr) addrQ <= addrIn;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic [DATA_W-1:0] rowQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rowQ <= '0;
      else if (strobes.storeWord && addrQ == ADDR_W'(i))
        rowQ <= wrData;
    end
    assign rows[i] = rowQ;
  end

  assign rdData   = strobes.driveRead ? rows[addrQ] : '0;
  assign rdDataEn = strobes.driveRead;

  // Shadow of the last commit, for the write check
  logic              wrSeen;
  logic [ADDR_W-1:0] chkAddr;
  logic [DATA_W-1:0] chkData;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeen  <= 1'b0;
      chkAddr <= '0;
      chkData <= '0;
    end else begin
      wrSeen <= strobes.storeWord;
      if (strobes.storeWord) begin
        chkAddr <= addrQ;
        chkData <= wrData;
      end
    end
  end

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchAddr |=> $stable(addrQ));

  assert_read_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdDataEn |-> !strobes.storeWord);

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrSeen |-> (rows[chkAddr] == chkData));

endmodule

// File: rtl/wait_mem_slave.sv
module wait_mem_slave
  import wms_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memSel,
  input  logic              readNotWrite,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataEn,
  output logic              waitOut
);

  strobe_t strobes;

  wms_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .memSel       (memSel),
    .readNotWrite (readNotWrite),
    .strobes      (strobes),
    .waitOut      (waitOut)
  );

  wms_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrIn   (addrIn),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdDataEn (rdDataEn)
  );

endmodule

// File: tb/wait_mem_slave_bench.sv
module wait_mem_slave_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          memSelB [2];
  logic          rdB     [2];
  logic [AW-1:0] addrB   [2];
  logic [DW-1:0] wdB     [2];
  logic [DW-1:0] rdDataO [2];
  logic          rdEnO   [2];
  logic          waitO   [2];

  int checks = 0;
  int fails  = 0;
  int expMem [2][NA];

  wait_mem_slave #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(3)) u_wait_mem_slave (
    .clk(clk), .rstN(rstN), .memSel(memSelB[0]), .readNotWrite(rdB[0]),
    .addrIn(addrB[0]), .wrData(wdB[0]), .rdData(rdDataO[0]),
    .rdDataEn(rdEnO[0]), .waitOut(waitO[0]));

  wait_mem_slave #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(1)) u_wait_mem_slave_fast (
    .clk(clk), .rstN(rstN), .memSel(memSelB[1]), .readNotWrite(rdB[1]),
    .addrIn(addrB[1]), .wrData(wdB[1]), .rdData(rdDataO[1]),
    .rdDataEn(rdEnO[1]), .waitOut(waitO[1]));

  function automatic int latOf(int idx);
    return (idx == 0) ? 3 : 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One access, started at a falling edge; ends at a falling edge with memSel
  // still as left (high unless abandoned). abortAt: drop memSel in that cycle.
  task automatic access(int idx, bit isRead, int addr, int data,
                        int abortAt, bit dropRd);
    int  lat = latOf(idx);
    bit  gone = 1'b0;
    memSelB[idx] = 1'b1;
    rdB[idx]     = isRead;
    addrB[idx]   = AW'(addr);
    wdB[idx]     = DW'(data);
    for (int k = 1; k <= lat && !gone; k++) begin
      @(posedge clk); @(negedge clk);
      chk($sformatf("R4/R5 wait inst%0d cycle%0d", idx, k), int'(waitO[idx]), (k < lat) ? 1 : 0);
      if (k < lat) begin
        chk("R6 no enable in wait", int'(rdEnO[idx]), 0);
        chk("R6 zero data in wait", int'(rdDataO[idx]), 0);
      end else begin
        chk("R6 enable in data cycle", int'(rdEnO[idx]), isRead ? 1 : 0);
        chk("R6 read data word", int'(rdDataO[idx]), isRead ? expMem[idx][addr] : 0);
      end
      if (k == 1) addrB[idx] = AW'(addr ^ 5);  // R3 later address changes ignored
      if (abortAt == k) begin
        memSelB[idx] = 1'b0;
        gone = 1'b1;
      end
      if (k == lat && dropRd && isRead && !gone) begin
        rdB[idx] = 1'b0;
        #1;
        chk("R10 enable falls with rd", int'(rdEnO[idx]), 0);
      end
    end
    @(posedge clk); @(negedge clk);
    if (!isRead && !gone) expMem[idx][addr] = data & 8'hFF;
    chk(gone ? "R8 idle after abandon" : "R9 idle after data cycle", int'(waitO[idx]), 0);
    chk("R9 no enable after data cycle", int'(rdEnO[idx]), 0);
  endtask

  task automatic quietBus(int idx, int cycles);
    for (int c = 0; c < cycles; c++) begin
      memSelB[idx] = 1'b0;
      rdB[idx]     = c[0];
      addrB[idx]   = AW'(c * 3);
      wdB[idx]     = DW'(8'hA5 ^ c);
      @(posedge clk); @(negedge clk);
      chk("R2 no wait on io", int'(waitO[idx]), 0);
      chk("R2 no enable on io", int'(rdEnO[idx]), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      memSelB[i] = 1'b0; rdB[i] = 1'b0; addrB[i] = '0; wdB[i] = '0;
      for (int a = 0; a < NA; a++) expMem[i][a] = 0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R1 reset wait", int'(waitO[i]), 0);
      chk("R1 reset enable", int'(rdEnO[i]), 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    for (int idx = 0; idx < 2; idx++) begin
      access(idx, 1'b1, 5, 0, 0, 1'b0);              // R1 array cleared
      memSelB[idx] = 1'b0;
      @(negedge clk);
      // R7 back-to-back writes over every address (R9 continuous memSel)
      for (int a = 0; a < NA; a++)
        access(idx, 1'b0, a, (a * 29 + 11 + idx * 64) & 255, 0, 1'b0);
      for (int a = 0; a < NA; a++)
        access(idx, 1'b1, a, 0, 0, 1'b0);
      quietBus(idx, 6);                                // R2
      for (int a = 0; a < NA; a++)
        access(idx, 1'b1, a, 0, 0, 1'b0);
      // R8 abandoned writes: early in the transfer and just before commit
      access(idx, 1'b0, 3, 8'h3C, 1, 1'b0);
      access(idx, 1'b0, 3, 8'hC3, latOf(idx), 1'b0);
      access(idx, 1'b1, 3, 0, 0, 1'b0);
      // R10 rd dropped in data cycle; no store follows
      wdB[idx] = 8'hEE;
      access(idx, 1'b1, 7, 0, 0, 1'b1);
      access(idx, 1'b1, 7, 0, 0, 1'b0);
      memSelB[idx] = 1'b0;
      @(negedge clk);
    end
    finishRun();
  end

endmodule